// File: doc/BRIEF.md
# Execute Writeback Slot and Redirect Arbiter

This block sits at the execute stage of an out-of-order core. It receives one group of issued instructions per cycle, one lane per issue slot. It walks the lanes from the lowest index up. Each walked instruction that is not squashed takes one functional unit. The walk ends at the first empty lane, once the execute width has been used up, or at the last lane. Squashed instructions skip the functional units. They are handed straight on to commit in their own lane.

Executed instructions are given writeback positions in a small buffer of time rows. Each row holds a fixed number of write ports. Every instruction is treated as having one cycle of latency. The scan tries the ports of the nearest row first and only then moves to later rows. The nearest row is released to commit on every clock.

From the same group the block picks at most one fetch redirect. It is the first executed lane that reports either a branch mispredict or a memory-order violation from the load/store queue. A mispredict wins over a violation on the same lane. The chosen redirect goes back to the front end with its sequence number and target. Two event counters record wrong-taken predictions and ordering violations.

Top module: `exec_wb_arbiter`

## Requirements
- R1: While `rstN` is low, every output is zero. This includes both counters, `wbValid`, `redirValid` and `errOverflow`.
- R2: The lane walk ends at the first lane whose `grpValid` bit is 0. Later lanes have no effect on any output, even when they are valid or flagged.
- R3: At most `ExecWidth` non-squashed lanes are executed per group (default 3). The walk ends when that limit is reached, so later lanes are ignored whether or not they are squashed. `fuUsed` reports the count one cycle after the group.
- R4: A walked lane with `grpSquashed`=1 raises its own bit in `fwdSquashed` one cycle after the group. It is not counted in `fuUsed` and takes no writeback position.
- R5: Each executed lane, in lane order, takes the first free position of the buffer. The scan goes port 0 upward within a row, then moves to the next row. Row t reaches `wbValid`/`wbSeq` t+1 cycles after the group. `wbValid` is always filled from bit 0 upward.
- R6: When an executed lane finds no free position in any of the `TimeSlots` rows (default 5), it is dropped. `errOverflow` is then 1 in the following cycle.
- R7: At most one redirect is raised per group. It comes from the lowest executed lane that has `grpMispred` or `grpMemViol` set. Flags on later lanes are ignored, and `redirValid` is a one-cycle pulse one cycle after the group.
- R8: When the chosen lane has both `grpMispred` and `grpMemViol` set, it is treated as a branch redirect.
- R9: A branch redirect sets `redirMispred`=1. It drives the lane's sequence number on `redirSeq`, its PC on `redirPc` and its next PC on `redirTarget`. It also sets `redirTaken`=1 exactly when the next PC differs from PC + `InstBytes` (default 4).
- R10: A memory-order redirect sets `redirMispred`=0, `redirTaken`=0 and `redirPc`=0. It drives the lane's next PC on `redirTarget`, and `cntMemViol` goes up by one.
- R11: `cntWrongTaken` goes up by one on a branch redirect whose lane has `grpPredTaken`=1, and changes at no other time.
- R12: The mispredict and violation flags of a squashed lane never raise a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpValid | input | IssueWidth | Lane holds an instruction |
| grpSquashed | input | IssueWidth | Lane instruction is squashed |
| grpMispred | input | IssueWidth | Lane branch was mispredicted |
| grpPredTaken | input | IssueWidth | Lane branch was predicted taken |
| grpMemViol | input | IssueWidth | Load/store queue reports an ordering violation at this lane |
| grpSeq | input | IssueWidth x SeqW | Lane sequence numbers |
| grpPc | input | IssueWidth x PcW | Lane PCs |
| grpNextPc | input | IssueWidth x PcW | Lane resolved next PCs |
| fwdSquashed | output | IssueWidth | Squashed lanes forwarded to commit |
| fuUsed | output | clog2(ExecWidth+1) | Functional units used by the last group |
| wbValid | output | WbPorts | Occupied ports of the row leaving for commit |
| wbSeq | output | WbPorts x SeqW | Sequence numbers of that row |
| redirValid | output | 1 | Redirect pulse |
| redirMispred | output | 1 | Redirect is a branch mispredict |
| redirTaken | output | 1 | Corrected taken direction |
| redirSeq | output | SeqW | Sequence number of the redirecting instruction |
| redirPc | output | PcW | PC of the mispredicted branch |
| redirTarget | output | PcW | Fetch restart address |
| cntWrongTaken | output | CntW | Wrong predicted-taken count |
| cntMemViol | output | CntW | Memory-order violation count |
| errOverflow | output | 1 | Writeback buffer overflow in the last group |

## Verification
Every result is registered once. The lane flags, `fuUsed`, the redirect fields, the counters and `errOverflow` are therefore due one cycle after the group is presented. A position in row t shows on `wbValid` t+1 cycles after its group. Each scenario task drives inputs between edges, steps one edge and samples just after it, then steps again to catch later rows or the end of a pulse. For the overflow sequence the bench keeps a count of buffer occupancy, worked out from R5 and R6, to predict the cycle in which `errOverflow` must rise.

// File: rtl/exec_wb_pkg.sv
package exec_wb_pkg;
  typedef enum logic [1:0] {
    RDK_NONE   = 2'd0,
    RDK_BRANCH = 2'd1,
    RDK_MEMORD = 2'd2
  } redirKind_t;

  typedef struct packed {
    logic       hit;
    redirKind_t kind;
  } redirStrobe_t;
endpackage

// File: rtl/exec_wb_ctl.sv
module exec_wb_ctl
  import exec_wb_pkg::*;
#(
  parameter int IssueWidth = 4,
  parameter int ExecWidth  = 3,
  localparam int FuW  = $clog2(ExecWidth + 1),
  localparam int IdxW = (IssueWidth > 1) ? $clog2(IssueWidth) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IssueWidth-1:0] grpValid,
  input  logic [IssueWidth-1:0] grpSquashed,
  input  logic [IssueWidth-1:0] grpMispred,
  input  logic [IssueWidth-1:0] grpMemViol,
  output logic [IssueWidth-1:0] execSel,
  output logic [IssueWidth-1:0] sqSel,
  output logic [FuW-1:0]        fuCnt,
  output redirStrobe_t          redirStb,
  output logic [IdxW-1:0]       redirIdx
);
  logic                  walking;
  logic [IssueWidth-1:0] redirOh;

  // Lane walk: stop at empty lane or exhausted functional units
  always_comb begin
    walking  = 1'b1;
    fuCnt    = '0;
    execSel  = '0;
    sqSel    = '0;
    redirOh  = '0;
    redirStb = '{hit: 1'b0, kind: RDK_NONE};
    for (int i = 0; i < IssueWidth; i++) begin
      if (walking) begin
        if (!grpValid[i] || fuCnt == FuW'(ExecWidth)) begin
          walking = 1'b0;
        end else if (grpSquashed[i]) begin
          sqSel[i] = 1'b1;
        end else begin
          execSel[i] = 1'b1;
          fuCnt = fuCnt + 1'b1;
          if (!redirStb.hit && (grpMispred[i] || grpMemViol[i])) begin
            redirOh[i]    = 1'b1;
            redirStb.hit  = 1'b1;
            redirStb.kind = grpMispred[i] ? RDK_BRANCH : RDK_MEMORD;
          end
        end
      end
    end
  end

  always_comb begin
    redirIdx = '0;
    for (int i = 0; i < IssueWidth; i++) begin
      if (redirOh[i]) redirIdx = IdxW'(i);
    end
  end

  assert_fu_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(execSel) <= ExecWidth);

  assert_single_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(redirOh));

  assert_redirect_not_squashed_R12: assert property (@(posedge clk) disable iff (!rstN)
    (redirOh & grpSquashed) == '0);
endmodule

// File: rtl/exec_wb_dp.sv
module exec_wb_dp
  import exec_wb_pkg::*;
#(
  parameter int IssueWidth = 4,
  parameter int ExecWidth  = 3,
  parameter int WbPorts    = 2,
  parameter int TimeSlots  = 5,
  parameter int PcW        = 32,
  parameter int SeqW       = 16,
  parameter int CntW       = 16,
  parameter int InstBytes  = 4,
  localparam int FuW  = $clog2(ExecWidth + 1),
  localparam int IdxW = (IssueWidth > 1) ? $clog2(IssueWidth) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [IssueWidth-1:0]            execSel,
  input  logic [IssueWidth-1:0]            sqSel,
  input  logic [FuW-1:0]                   fuCnt,
  input  redirStrobe_t                     redirStb,
  input  logic [IdxW-1:0]                  redirIdx,
  input  logic [IssueWidth-1:0]            grpPredTaken,
  input  logic [IssueWidth-1:0][SeqW-1:0]  grpSeq,
  input  logic [IssueWidth-1:0][PcW-1:0]   grpPc,
  input  logic [IssueWidth-1:0][PcW-1:0]   grpNextPc,
  output logic [IssueWidth-1:0]            fwdSquashed,
  output logic [FuW-1:0]                   fuUsed,
  output logic [WbPorts-1:0]               wbValid,
  output logic [WbPorts-1:0][SeqW-1:0]     wbSeq,
  output logic                             redirValid,
  output logic                             redirMispred,
  output logic                             redirTaken,
  output logic [SeqW-1:0]                  redirSeq,
  output logic [PcW-1:0]                   redirPc,
  output logic [PcW-1:0]                   redirTarget,
  output logic [CntW-1:0]                  cntWrongTaken,
  output logic [CntW-1:0]                  cntMemViol,
  output logic                             errOverflow
);
  logic [WbPorts-1:0]            occ     [TimeSlots];
  logic [WbPorts-1:0][SeqW-1:0]  seqBuf  [TimeSlots];
  logic [WbPorts-1:0]            nOcc    [TimeSlots];
  logic [WbPorts-1:0][SeqW-1:0]  nSeq    [TimeSlots];
  logic                          placed;
  logic                          ovf;
  logic                          isBranch;
  logic                          takenFix;

  // First-free placement: ports of a row first, then later rows
  always_comb begin
    nOcc   = occ;
    nSeq   = seqBuf;
    ovf    = 1'b0;
    placed = 1'b0;
    for (int i = 0; i < IssueWidth; i++) begin
      if (execSel[i]) begin
        placed = 1'b0;
        for (int t = 0; t < TimeSlots; t++) begin
          for (int p = 0; p < WbPorts; p++) begin
            if (!placed && !nOcc[t][p]) begin
              nOcc[t][p] = 1'b1;
              nSeq[t][p] = grpSeq[i];
              placed     = 1'b1;
            end
          end
        end
        if (!placed) ovf = 1'b1;
      end
    end
  end

  assign isBranch = redirStb.hit && (redirStb.kind == RDK_BRANCH);
  assign takenFix = grpNextPc[redirIdx] != (grpPc[redirIdx] + PcW'(InstBytes));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < TimeSlots; t++) begin
        occ[t]    <= '0;
        seqBuf[t] <= '0;
      end
      wbValid       <= '0;
      wbSeq         <= '0;
      fwdSquashed   <= '0;
      fuUsed        <= '0;
      errOverflow   <= 1'b0;
      redirValid    <= 1'b0;
      redirMispred  <= 1'b0;
      redirTaken    <= 1'b0;
      redirSeq      <= '0;
      redirPc       <= '0;
      redirTarget   <= '0;
      cntWrongTaken <= '0;
      cntMemViol    <= '0;
    end else begin
      wbValid <= nOcc[0];
      wbSeq   <= nSeq[0];
      for (int t = 0; t < TimeSlots - 1; t++) begin
        occ[t]    <= nOcc[t+1];
        seqBuf[t] <= nSeq[t+1];
      end
      occ[TimeSlots-1]    <= '0;
      seqBuf[TimeSlots-1] <= '0;
      fwdSquashed  <= sqSel;
      fuUsed       <= fuCnt;
      errOverflow  <= ovf;
      redirValid   <= redirStb.hit;
      redirMispred <= isBranch;
      redirTaken   <= isBranch && takenFix;
      redirSeq     <= redirStb.hit ? grpSeq[redirIdx] : '0;
      redirPc      <= isBranch ? grpPc[redirIdx] : '0;
      redirTarget  <= redirStb.hit ? grpNextPc[redirIdx] : '0;
      if (isBranch && grpPredTaken[redirIdx]) cntWrongTaken <= cntWrongTaken + 1'b1;
      if (redirStb.hit && redirStb.kind == RDK_MEMORD) cntMemViol <= cntMemViol + 1'b1;
    end
  end

  assert_wb_packed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid & (wbValid + 1'b1)) == '0);

  assert_memviol_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !redirMispred) |-> (cntMemViol == $past(cntMemViol) + 1'b1));

  assert_wrong_taken_only_on_branch_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrongTaken != $past(cntWrongTaken)) |-> (redirValid && redirMispred));

  assert_memord_fields_R10: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !redirMispred) |-> (!redirTaken && redirPc == '0));
endmodule

// File: rtl/exec_wb_arbiter.sv
module exec_wb_arbiter
  import exec_wb_pkg::*;
#(
  parameter int IssueWidth = 4,
  parameter int ExecWidth  = 3,
  parameter int WbPorts    = 2,
  parameter int TimeSlots  = 5,
  parameter int PcW        = 32,
  parameter int SeqW       = 16,
  parameter int CntW       = 16,
  parameter int InstBytes  = 4,
  localparam int FuW  = $clog2(ExecWidth + 1),
  localparam int IdxW = (IssueWidth > 1) ? $clog2(IssueWidth) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [IssueWidth-1:0]            grpValid,
  input  logic [IssueWidth-1:0]            grpSquashed,
  input  logic [IssueWidth-1:0]            grpMispred,
  input  logic [IssueWidth-1:0]            grpPredTaken,
  input  logic [IssueWidth-1:0]            grpMemViol,
  input  logic [IssueWidth-1:0][SeqW-1:0]  grpSeq,
  input  logic [IssueWidth-1:0][PcW-1:0]   grpPc,
  input  logic [IssueWidth-1:0][PcW-1:0]   grpNextPc,
  output logic [IssueWidth-1:0]            fwdSquashed,
  output logic [FuW-1:0]                   fuUsed,
  output logic [WbPorts-1:0]               wbValid,
  output logic [WbPorts-1:0][SeqW-1:0]     wbSeq,
  output logic                             redirValid,
  output logic                             redirMispred,
  output logic                             redirTaken,
  output logic [SeqW-1:0]                  redirSeq,
  output logic [PcW-1:0]                   redirPc,
  output logic [PcW-1:0]                   redirTarget,
  output logic [CntW-1:0]                  cntWrongTaken,
  output logic [CntW-1:0]                  cntMemViol,
  output logic                             errOverflow
);
  logic [IssueWidth-1:0] execSel;
  logic [IssueWidth-1:0] sqSel;
  logic [FuW-1:0]        fuCnt;
  redirStrobe_t          redirStb;
  logic [IdxW-1:0]       redirIdx;

  exec_wb_ctl #(.IssueWidth(IssueWidth), .ExecWidth(ExecWidth)) ctl_i (
    .clk(clk), .rstN(rstN),
    .grpValid(grpValid), .grpSquashed(grpSquashed),
    .grpMispred(grpMispred), .grpMemViol(grpMemViol),
    .execSel(execSel), .sqSel(sqSel), .fuCnt(fuCnt),
    .redirStb(redirStb), .redirIdx(redirIdx)
  );

  exec_wb_dp #(
    .IssueWidth(IssueWidth), .ExecWidth(ExecWidth), .WbPorts(WbPorts),
    .TimeSlots(TimeSlots), .PcW(PcW), .SeqW(SeqW), .CntW(CntW),
    .InstBytes(InstBytes)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .execSel(execSel), .sqSel(sqSel), .fuCnt(fuCnt),
    .redirStb(redirStb), .redirIdx(redirIdx),
    .grpPredTaken(grpPredTaken), .grpSeq(grpSeq),
    .grpPc(grpPc), .grpNextPc(grpNextPc),
    .fwdSquashed(fwdSquashed), .fuUsed(fuUsed),
    .wbValid(wbValid), .wbSeq(wbSeq),
    .redirValid(redirValid), .redirMispred(redirMispred),
    .redirTaken(redirTaken), .redirSeq(redirSeq),
    .redirPc(redirPc), .redirTarget(redirTarget),
    .cntWrongTaken(cntWrongTaken), .cntMemViol(cntMemViol),
    .errOverflow(errOverflow)
  );
endmodule

// File: tb/exec_wb_arbiter_tb.sv
module exec_wb_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW   = 4;
  localparam int EW   = 3;
  localparam int WP   = 2;
  localparam int TS   = 5;
  localparam int PcW  = 32;
  localparam int SeqW = 16;
  localparam int CntW = 16;
  localparam int FuW  = $clog2(EW + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IW-1:0] grpValid, grpSquashed, grpMispred, grpPredTaken, grpMemViol;
  logic [IW-1:0][SeqW-1:0] grpSeq;
  logic [IW-1:0][PcW-1:0]  grpPc, grpNextPc;
  logic [IW-1:0] fwdSquashed;
  logic [FuW-1:0] fuUsed;
  logic [WP-1:0] wbValid;
  logic [WP-1:0][SeqW-1:0] wbSeq;
  logic redirValid, redirMispred, redirTaken, errOverflow;
  logic [SeqW-1:0] redirSeq;
  logic [PcW-1:0] redirPc, redirTarget;
  logic [CntW-1:0] cntWrongTaken, cntMemViol;

  int checks = 0;
  int failures = 0;
  int expWt = 0;
  int expMv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_wb_arbiter #(.IssueWidth(IW), .ExecWidth(EW), .WbPorts(WP), .TimeSlots(TS),
                    .PcW(PcW), .SeqW(SeqW), .CntW(CntW), .InstBytes(4)) dut_i (
    .clk(clk), .rstN(rstN),
    .grpValid(grpValid), .grpSquashed(grpSquashed), .grpMispred(grpMispred),
    .grpPredTaken(grpPredTaken), .grpMemViol(grpMemViol),
    .grpSeq(grpSeq), .grpPc(grpPc), .grpNextPc(grpNextPc),
    .fwdSquashed(fwdSquashed), .fuUsed(fuUsed), .wbValid(wbValid), .wbSeq(wbSeq),
    .redirValid(redirValid), .redirMispred(redirMispred), .redirTaken(redirTaken),
    .redirSeq(redirSeq), .redirPc(redirPc), .redirTarget(redirTarget),
    .cntWrongTaken(cntWrongTaken), .cntMemViol(cntMemViol), .errOverflow(errOverflow)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearGrp();
    grpValid = '0; grpSquashed = '0; grpMispred = '0;
    grpPredTaken = '0; grpMemViol = '0;
    grpSeq = '0; grpPc = '0; grpNextPc = '0;
  endtask

  task automatic setLane(input int i, input logic sq, input logic mis, input logic pt,
                         input logic mv, input int seq, input int pc, input int npc);
    grpValid[i] = 1'b1; grpSquashed[i] = sq; grpMispred[i] = mis;
    grpPredTaken[i] = pt; grpMemViol[i] = mv;
    grpSeq[i] = SeqW'(seq); grpPc[i] = PcW'(pc); grpNextPc[i] = PcW'(npc);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    clearGrp();
    repeat (TS + 1) step();
  endtask

  task automatic checkCounters(input string req);
    check({req, " cntWrongTaken"}, 64'(cntWrongTaken), 64'(expWt));
    check({req, " cntMemViol"}, 64'(cntMemViol), 64'(expMv));
  endtask

  task automatic t_reset();
    check("R1 wbValid", 64'(wbValid), 0);
    check("R1 redirValid", 64'(redirValid), 0);
    check("R1 errOverflow", 64'(errOverflow), 0);
    check("R1 fuUsed", 64'(fuUsed), 0);
    checkCounters("R1");
  endtask

  task automatic t_basic_wb();
    clearGrp();
    setLane(0, 0, 0, 0, 0, 10, 'h10, 'h14);
    setLane(1, 0, 0, 0, 0, 11, 'h14, 'h18);
    setLane(2, 0, 0, 0, 0, 12, 'h18, 'h1c);
    step(); clearGrp();
    check("R5 row0 valid", 64'(wbValid), 64'b11);
    check("R5 port0 seq", 64'(wbSeq[0]), 10);
    check("R5 port1 seq", 64'(wbSeq[1]), 11);
    check("R3 fuUsed three", 64'(fuUsed), 3);
    check("R4 no squashed", 64'(fwdSquashed), 0);
    step();
    check("R5 row1 valid", 64'(wbValid), 64'b01);
    check("R5 row1 seq", 64'(wbSeq[0]), 12);
    step();
    check("R5 empty after drain", 64'(wbValid), 0);
  endtask

  task automatic t_empty_stop();
    clearGrp();
    setLane(0, 0, 0, 0, 0, 20, 'h20, 'h24);
    setLane(2, 0, 1, 1, 0, 22, 'h28, 'h80);
    setLane(3, 1, 0, 0, 0, 23, 'h2c, 'h30);
    step(); clearGrp();
    check("R2 fuUsed stops at gap", 64'(fuUsed), 1);
    check("R2 no redirect past gap", 64'(redirValid), 0);
    check("R2 no squash past gap", 64'(fwdSquashed), 0);
    check("R2 one writeback", 64'(wbValid), 64'b01);
    checkCounters("R2");
    drain();
  endtask

  task automatic t_fu_limit();
    clearGrp();
    setLane(0, 0, 0, 0, 0, 30, 'h30, 'h34);
    setLane(1, 0, 0, 0, 0, 31, 'h34, 'h38);
    setLane(2, 0, 0, 0, 0, 32, 'h38, 'h3c);
    setLane(3, 1, 1, 1, 1, 33, 'h3c, 'h90);
    step(); clearGrp();
    check("R3 fuUsed capped", 64'(fuUsed), 3);
    check("R3 squashed lane beyond limit not forwarded", 64'(fwdSquashed), 0);
    check("R3 no redirect beyond limit", 64'(redirValid), 0);
    step();
    check("R3 one left in row1", 64'(wbValid), 64'b01);
    check("R3 row1 seq", 64'(wbSeq[0]), 32);
    drain();
  endtask

  task automatic t_squash();
    clearGrp();
    setLane(0, 1, 1, 1, 1, 40, 'h40, 'h100);
    setLane(1, 0, 0, 0, 0, 41, 'h44, 'h48);
    setLane(2, 0, 0, 0, 0, 42, 'h48, 'h4c);
    setLane(3, 0, 0, 0, 0, 43, 'h4c, 'h50);
    step(); clearGrp();
    check("R4 squashed forwarded", 64'(fwdSquashed), 64'b0001);
    check("R4 squashed not counted", 64'(fuUsed), 3);
    check("R12 squashed flags no redirect", 64'(redirValid), 0);
    check("R4 first executed at port0", 64'(wbSeq[0]), 41);
    checkCounters("R12");
    drain();
  endtask

  task automatic t_branch();
    clearGrp();
    setLane(0, 0, 0, 0, 0, 50, 'h0fc, 'h100);
    setLane(1, 0, 1, 1, 1, 51, 'h100, 'h200);
    setLane(2, 0, 1, 1, 0, 52, 'h200, 'h300);
    step(); clearGrp();
    expWt++;
    check("R8 mispredict wins", 64'(redirMispred), 1);
    check("R9 redirValid", 64'(redirValid), 1);
    check("R9 seq", 64'(redirSeq), 51);
    check("R9 pc", 64'(redirPc), 'h100);
    check("R9 target", 64'(redirTarget), 'h200);
    check("R9 taken fix", 64'(redirTaken), 1);
    checkCounters("R11");
    step();
    check("R7 redirect pulse ends", 64'(redirValid), 0);
    setLane(0, 0, 1, 0, 0, 55, 'h300, 'h304);
    step(); clearGrp();
    check("R9 fallthrough taken fix", 64'(redirTaken), 0);
    check("R9 mispred flag", 64'(redirMispred), 1);
    checkCounters("R11 not-taken prediction");
    drain();
  endtask

  task automatic t_memord();
    clearGrp();
    setLane(0, 0, 0, 0, 1, 60, 'h400, 'h404);
    setLane(1, 0, 1, 1, 0, 61, 'h404, 'h500);
    step(); clearGrp();
    expMv++;
    check("R7 first lane chosen", 64'(redirSeq), 60);
    check("R10 redirValid", 64'(redirValid), 1);
    check("R10 no mispred", 64'(redirMispred), 0);
    check("R10 no taken", 64'(redirTaken), 0);
    check("R10 pc zero", 64'(redirPc), 0);
    check("R10 target", 64'(redirTarget), 'h404);
    checkCounters("R10");
    drain();
  endtask

  task automatic t_overflow();
    int occ = 0;
    for (int k = 0; k < 10; k++) begin
      int placed;
      logic expErr;
      clearGrp();
      for (int i = 0; i < 3; i++) setLane(i, 0, 0, 0, 0, 100 + k*4 + i, 'h0, 'h4);
      expErr = (occ + 3 > TS * WP);
      placed = expErr ? (TS * WP - occ) : 3;
      occ = occ + placed - WP;
      if (occ < 0) occ = 0;
      step();
      check($sformatf("R6 overflow group %0d", k), 64'(errOverflow), 64'(expErr));
    end
    clearGrp();
    step();
    check("R6 overflow clears", 64'(errOverflow), 0);
    drain();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearGrp();
    repeat (3) step();
    t_reset();
    rstN = 1'b1;
    step();
    t_basic_wb();
    t_empty_stop();
    t_fu_limit();
    t_squash();
    t_branch();
    t_memord();
    t_overflow();
    checkCounters("R11 final");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule